// File: doc/BRIEF.md
# Write Command Timing Guard

This block sits on the controller side of a double-data-rate memory interface and decides, in the same cycle a command is requested, whether that read, write or precharge may go out after earlier write bursts. It keeps a small set of down-counters for every bank. These counters follow how many write data pairs are still arriving, the write-to-read and write-recovery windows measured from the last data pair, and the row-precharge window after a bank is closed. Each interval is a cycle count supplied by configuration inputs.

A read or precharge can be requested in one of two ways. In the polite form it waits until the write has finished and recovered. In the truncating form it is granted at once and cuts the burst short. When a truncating command throws away data pairs that are still due, the block raises an interrupt flag for that cycle. It then drives a mask-enable pulse, together with the bank number, for each discarded pair so the write datapath can mask them. A refused request is not dropped. The requester holds it and the grant rises in the first cycle the counters allow it. A write marked for auto-precharge closes the bank on exactly the same cycle as a manual precharge issued at the earliest legal time.

Top module: `wr_guard`

## Requirements
- R1: `grant` is combinational in the request cycle. It is high only when `req_valid` is high and `req_cmd` is not NOP. The command codes are 0 = NOP, 1 = read, 2 = write, 3 = precharge. An idle bank grants any command at once.
- R2: The write data pairs of a write granted in cycle W arrive in cycles W+1 to W+P, where P is half the burst length. A non-truncating read (`req_trunc` = 0) to that bank is held off and is granted no earlier than cycle W+P+`cfg_twtr`+1.
- R3: A non-truncating precharge to a bank written in cycle W is granted no earlier than cycle W+P+`cfg_twr`+1.
- R4: A truncating read or precharge (`req_trunc` = 1) is granted at once while write timing is still running. `interrupt` is high in that cycle only if more than one data pair of the bank is still due, counting the pair in the current cycle.
- R5: An interrupting grant in cycle G with d pairs still due drives `mask_en` high in cycles G+1 to G+d-1, with `mask_bank` equal to the bank of the request.
- R6: After a truncating read in cycle G that discarded data, a non-truncating precharge to that bank is granted no earlier than cycle G+`cfg_twr`+1.
- R7: After a precharge is granted in cycle Q, no command to that bank is granted before cycle Q+`cfg_trp`+1.
- R8: A write is refused only inside a row-precharge window. A second write may follow the first in the next cycle and restarts the data and interval counts from its own grant cycle.
- R9: A write with `req_ap` = 1 granted in cycle W blocks every command to its bank until cycle W+P+`cfg_twr`+`cfg_trp`+2. This is the same cycle at which a manual precharge issued at its earliest legal time would release the bank.
- R10: The counters are kept per bank. A write to one bank never delays a command to another bank.
- R11: `req_blen` selects the burst length: 0 gives 2, 1 gives 4, and 2 or 3 give 8 (P = 1, 2, 4).
- R12: While `rst` is high, `grant`, `interrupt` and `mask_en` stay low, and every bank comes out of reset idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command request is present and held until granted |
| req_cmd | input | 2 | Command code: 0 NOP, 1 read, 2 write, 3 precharge |
| req_bank | input | BANK_W (2) | Target bank |
| req_blen | input | 2 | Burst length code for writes |
| req_ap | input | 1 | Write closes its bank automatically |
| req_trunc | input | 1 | Read or precharge may cut a running write short |
| cfg_twtr | input | CFG_W (4) | Write-to-read interval in cycles |
| cfg_twr | input | CFG_W (4) | Write-recovery interval in cycles |
| cfg_trp | input | CFG_W (4) | Row-precharge interval in cycles |
| grant | output | 1 | Request accepted this cycle |
| interrupt | output | 1 | Granted command discards write data still due |
| mask_en | output | 1 | Mask the write data pair arriving this cycle |
| mask_bank | output | BANK_W (2) | Bank whose data pair is masked |

## Verification
`grant` and `interrupt` are combinational, so they are due in the very cycle whose counters permit the request. For a write in cycle W, that cycle is W+P+interval+1 for a polite follow-on command, and Q+`cfg_trp`+1 after a precharge in cycle Q. `mask_en` comes from a register and starts one cycle after the interrupting grant. The driver writes each request just after a falling edge. From the issue cycle it computes the exact cycle in which the grant is due, with the interrupt expected at that point and the mask run length, and queues these. The monitor samples one nanosecond later in every cycle and compares the grant cycle, the interrupt and the length and bank of each completed mask run against the front of the queues.

// File: rtl/wg_pkg.sv
package wg_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_PRE   = 2'd3
    } wg_cmd_e;

    // width of a data-pair count (longest burst is 8 beats = 4 pairs)
    localparam int PAIR_W = 3;

    // per-bank request event produced by the decision logic
    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              pre;
        logic              ap;
        logic [PAIR_W-1:0] pairs;
    } wg_bank_ev_t;

    // per-bank timing status seen by the decision logic
    typedef struct packed {
        logic [PAIR_W-1:0] data_left;
        logic              rd_clear;
        logic              pre_clear;
        logic              rp_clear;
    } wg_bank_stat_t;

    // burst-length code to number of data pairs
    function automatic logic [PAIR_W-1:0] pairs_of(input logic [1:0] blen);
        case (blen)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/wg_bank_timer.sv
module wg_bank_timer
    import wg_pkg::*;
#(
    parameter int CFG_W = 4,
    parameter int CNT_W = CFG_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  wg_bank_ev_t       ev,
    input  logic [CFG_W-1:0]  cfg_twtr,
    input  logic [CFG_W-1:0]  cfg_twr,
    input  logic [CFG_W-1:0]  cfg_trp,
    output wg_bank_stat_t     stat
);

    logic [PAIR_W-1:0] data_q;
    logic [CNT_W-1:0]  wtr_q;
    logic [CNT_W-1:0]  wr_q;
    logic [CNT_W-1:0]  rp_q;

    logic [CNT_W-1:0] pairs_x, twtr_x, twr_x, trp_x;
    assign pairs_x = CNT_W'(ev.pairs);
    assign twtr_x  = CNT_W'(cfg_twtr);
    assign twr_x   = CNT_W'(cfg_twr);
    assign trp_x   = CNT_W'(cfg_trp);

    function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic logic [PAIR_W-1:0] dec_p(input logic [PAIR_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            wtr_q  <= '0;
            wr_q   <= '0;
            rp_q   <= '0;
        end else if (ev.wr) begin
            // new burst: intervals run from the last data pair
            data_q <= ev.pairs;
            wtr_q  <= pairs_x + twtr_x;
            wr_q   <= pairs_x + twr_x;
            rp_q   <= ev.ap ? (pairs_x + twr_x + trp_x + 1'b1) : '0;
        end else if (ev.pre) begin
            data_q <= '0;
            wtr_q  <= '0;
            wr_q   <= '0;
            rp_q   <= trp_x;
        end else if (ev.rd) begin
            wtr_q  <= '0;
            data_q <= '0;
            rp_q   <= dec(rp_q);
            // truncation moves the end of write data to this cycle
            wr_q   <= (data_q != '0) ? twr_x : dec(wr_q);
        end else begin
            data_q <= dec_p(data_q);
            wtr_q  <= dec(wtr_q);
            wr_q   <= dec(wr_q);
            rp_q   <= dec(rp_q);
        end
    end

    always_comb begin
        stat.data_left = data_q;
        stat.rd_clear  = (wtr_q == '0);
        stat.pre_clear = (wr_q == '0);
        stat.rp_clear  = (rp_q == '0);
    end

endmodule

// File: rtl/wg_decide.sv
module wg_decide
    import wg_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BANK_W = $clog2(NBANK)
) (
    input  logic                       rst,
    input  logic                       req_valid,
    input  wg_cmd_e                    req_cmd,
    input  logic [BANK_W-1:0]          req_bank,
    input  logic [PAIR_W-1:0]          req_pairs,
    input  logic                       req_ap,
    input  logic                       req_trunc,
    input  wg_bank_stat_t [NBANK-1:0]  stat,
    output wg_bank_ev_t   [NBANK-1:0]  ev,
    output logic                       grant,
    output logic                       interrupt,
    output logic [PAIR_W-1:0]          mask_len
);

    wg_bank_stat_t sel;
    logic          ok;
    logic          cuts;

    always_comb begin
        sel = stat[req_bank];
        case (req_cmd)
            CMD_READ:  ok = sel.rp_clear && (req_trunc || sel.rd_clear);
            CMD_WRITE: ok = sel.rp_clear;
            CMD_PRE:   ok = sel.rp_clear && (req_trunc || sel.pre_clear);
            default:   ok = 1'b0;
        endcase
        grant     = req_valid && ok && !rst;
        cuts      = req_trunc && (req_cmd == CMD_READ || req_cmd == CMD_PRE);
        interrupt = grant && cuts && (sel.data_left > 3'd1);
        mask_len  = (sel.data_left == '0) ? '0 : sel.data_left - 3'd1;
    end

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            ev[b].wr    = grant && (req_cmd == CMD_WRITE) && (req_bank == BANK_W'(b));
            ev[b].rd    = grant && (req_cmd == CMD_READ)  && (req_bank == BANK_W'(b));
            ev[b].pre   = grant && (req_cmd == CMD_PRE)   && (req_bank == BANK_W'(b));
            ev[b].ap    = req_ap;
            ev[b].pairs = req_pairs;
        end
    end

endmodule

// File: rtl/wg_mask.sv
module wg_mask
    import wg_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAIR_W-1:0] load_len,
    input  logic [BANK_W-1:0] load_bank,
    output logic              mask_en,
    output logic [BANK_W-1:0] mask_bank
);

    logic [PAIR_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q    <= '0;
            mask_bank <= '0;
        end else if (load) begin
            left_q    <= load_len;
            mask_bank <= load_bank;
        end else if (left_q != '0) begin
            left_q    <= left_q - 1'b1;
        end
    end

    assign mask_en = (left_q != '0);

endmodule

// File: rtl/wr_guard.sv
module wr_guard
    import wg_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int CFG_W  = 4,
    localparam int BANK_W = $clog2(NBANK),
    localparam int CNT_W  = CFG_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [1:0]        req_blen,
    input  logic              req_ap,
    input  logic              req_trunc,
    input  logic [CFG_W-1:0]  cfg_twtr,
    input  logic [CFG_W-1:0]  cfg_twr,
    input  logic [CFG_W-1:0]  cfg_trp,
    output logic              grant,
    output logic              interrupt,
    output logic              mask_en,
    output logic [BANK_W-1:0] mask_bank
);

    wg_bank_stat_t [NBANK-1:0] stat;
    wg_bank_ev_t   [NBANK-1:0] ev;
    logic [PAIR_W-1:0]         mask_len;
    wg_cmd_e                   cmd;

    assign cmd = wg_cmd_e'(req_cmd);

    wg_decide #(
        .NBANK  (NBANK),
        .BANK_W (BANK_W)
    ) u_decide (
        .rst       (rst),
        .req_valid (req_valid),
        .req_cmd   (cmd),
        .req_bank  (req_bank),
        .req_pairs (pairs_of(req_blen)),
        .req_ap    (req_ap),
        .req_trunc (req_trunc),
        .stat      (stat),
        .ev        (ev),
        .grant     (grant),
        .interrupt (interrupt),
        .mask_len  (mask_len)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        wg_bank_timer #(
            .CFG_W (CFG_W),
            .CNT_W (CNT_W)
        ) u_timer (
            .clk      (clk),
            .rst      (rst),
            .ev       (ev[b]),
            .cfg_twtr (cfg_twtr),
            .cfg_twr  (cfg_twr),
            .cfg_trp  (cfg_trp),
            .stat     (stat[b])
        );
    end

    wg_mask #(
        .BANK_W (BANK_W)
    ) u_mask (
        .clk       (clk),
        .rst       (rst),
        .load      (interrupt),
        .load_len  (mask_len),
        .load_bank (req_bank),
        .mask_en   (mask_en),
        .mask_bank (mask_bank)
    );

endmodule

// File: rtl/wg_guard_chk.sv
module wg_guard_chk
    import wg_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int CFG_W = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_cmd,
    input logic [BANK_W-1:0] req_bank,
    input logic              req_ap,
    input logic              req_trunc,
    input logic [CFG_W-1:0]  cfg_trp,
    input logic              grant,
    input logic              interrupt,
    input logic              mask_en,
    input logic [BANK_W-1:0] mask_bank
);

    // R1: a grant only answers a real command
    p_grant_has_req_r1: assert property (@(posedge clk) disable iff (rst)
        grant |-> (req_valid && req_cmd != 2'(CMD_NOP)));

    // R4: only a truncating read or precharge can interrupt
    p_intr_is_trunc_r4: assert property (@(posedge clk) disable iff (rst)
        interrupt |-> (grant && req_trunc &&
                       (req_cmd == 2'(CMD_READ) || req_cmd == 2'(CMD_PRE))));

    // R5: an interrupt is followed by masking of the same bank
    p_intr_masks_r5: assert property (@(posedge clk) disable iff (rst)
        interrupt |=> (mask_en && mask_bank == $past(req_bank)));

    // R8: a write never interrupts
    p_write_no_intr_r8: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 2'(CMD_WRITE)) |-> !interrupt);

    // R2: no polite read to the written bank in the very next cycle
    p_no_rd_after_wr_r2: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 2'(CMD_WRITE) && !req_ap) |=>
        !(grant && req_cmd == 2'(CMD_READ) && !req_trunc &&
          req_bank == $past(req_bank)));

    // R7: a closing bank refuses the next cycle's command
    p_rp_block_r7: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 2'(CMD_PRE) && cfg_trp != '0) |=>
        !(grant && req_bank == $past(req_bank)));

endmodule

bind wr_guard wg_guard_chk #(
    .NBANK (NBANK),
    .CFG_W (CFG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_bank  (req_bank),
    .req_ap    (req_ap),
    .req_trunc (req_trunc),
    .cfg_trp   (cfg_trp),
    .grant     (grant),
    .interrupt (interrupt),
    .mask_en   (mask_en),
    .mask_bank (mask_bank)
);

// File: tb/sim_wr_guard.sv
`timescale 1ns/1ps
module sim_wr_guard;

    localparam logic [1:0] NOP = 2'd0, RD = 2'd1, WR = 2'd2, PR = 2'd3;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [1:0] req_cmd;
    logic [1:0] req_bank;
    logic [1:0] req_blen;
    logic       req_ap;
    logic       req_trunc;
    logic [3:0] cfg_twtr, cfg_twr, cfg_trp;
    logic       grant, interrupt, mask_en;
    logic [1:0] mask_bank;

    typedef struct { int cyc; bit intr; string tag; } gexp_t;
    typedef struct { int len; int bank; string tag; } mexp_t;
    gexp_t gq[$];
    mexp_t mq[$];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    wr_guard u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_blen(req_blen), .req_ap(req_ap),
        .req_trunc(req_trunc), .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr),
        .cfg_trp(cfg_trp), .grant(grant), .interrupt(interrupt),
        .mask_en(mask_en), .mask_bank(mask_bank)
    );

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: called at a falling edge; returns at the falling edge after the grant
    task automatic issue(input logic [1:0] c, input int b, input logic [1:0] bl,
                         input bit ap, input bit tr, input int dly,
                         input bit intr, input int mlen, input string tag);
        bit g;
        req_valid = 1'b1;
        req_cmd   = c;
        req_bank  = 2'(b);
        req_blen  = bl;
        req_ap    = ap;
        req_trunc = tr;
        gq.push_back('{cyc + dly, intr, tag});
        if (intr) mq.push_back('{mlen, b, tag});
        do begin
            #1 g = grant;
            @(negedge clk);
        end while (!g);
        req_valid = 1'b0;
        req_cmd   = NOP;
        req_ap    = 1'b0;
        req_trunc = 1'b0;
    endtask

    // monitor: samples 1 ns after each falling edge
    initial begin
        int run;
        int rb;
        gexp_t e;
        mexp_t m;
        run = 0;
        rb  = 0;
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (grant) begin
                    if (gq.size() == 0) chk(1'b0, "R1 unexpected grant", 1, 0);
                    else begin
                        e = gq.pop_front();
                        chk(cyc == e.cyc, {e.tag, " grant cycle"}, cyc, e.cyc);
                        chk(interrupt == e.intr, {e.tag, " interrupt"}, int'(interrupt), int'(e.intr));
                    end
                end
                if (mask_en) begin
                    run++;
                    rb = int'(mask_bank);
                end else if (run != 0) begin
                    if (mq.size() == 0) chk(1'b0, "R5 unexpected mask run", run, 0);
                    else begin
                        m = mq.pop_front();
                        chk(run == m.len, {m.tag, " mask length"}, run, m.len);
                        chk(rb == m.bank, {m.tag, " mask bank"}, rb, m.bank);
                    end
                    run = 0;
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_cmd = NOP; req_bank = '0;
        req_blen = '0; req_ap = 1'b0; req_trunc = 1'b0;
        cfg_twtr = 4'd2; cfg_twr = 4'd3; cfg_trp = 4'd2;
        idle(3);
        // R12: outputs quiet in reset even with a request present
        req_valid = 1'b1; req_cmd = RD;
        #1;
        chk(grant == 1'b0, "R12 grant in reset", int'(grant), 0);
        chk(interrupt == 1'b0, "R12 interrupt in reset", int'(interrupt), 0);
        chk(mask_en == 1'b0, "R12 mask_en in reset", int'(mask_en), 0);
        @(negedge clk);
        rst = 1'b0; req_valid = 1'b0; req_cmd = NOP;
        idle(2);
        // R1: NOP is never granted
        req_valid = 1'b1; req_cmd = NOP;
        #1 chk(grant == 1'b0, "R1 NOP granted", int'(grant), 0);
        @(negedge clk);
        req_valid = 1'b0;
        // R1: idle bank grants at once
        issue(RD, 0, 2'd0, 0, 0, 0, 0, 0, "R1 idle read");
        idle(20);
        // R2 + R11: BL4 write then polite read
        issue(WR, 0, 2'd1, 0, 0, 0, 0, 0, "R8 write b0");
        issue(RD, 0, 2'd0, 0, 0, 4, 0, 0, "R2 read after BL4");
        idle(20);
        // R3, R7: BL8 write, polite precharge, then write after tRP
        issue(WR, 1, 2'd2, 0, 0, 0, 0, 0, "R11 write BL8");
        issue(PR, 1, 2'd0, 0, 0, 7, 0, 0, "R3 precharge after BL8");
        issue(WR, 1, 2'd1, 0, 0, 2, 0, 0, "R7 write after precharge");
        idle(20);
        // R10 + R11: BL2 write, other bank free, own bank waits
        issue(WR, 2, 2'd0, 0, 0, 0, 0, 0, "R11 write BL2");
        issue(RD, 3, 2'd0, 0, 0, 0, 0, 0, "R10 read other bank");
        issue(RD, 2, 2'd0, 0, 0, 2, 0, 0, "R2 read after BL2");
        idle(20);
        // R4, R5, R6: truncating read then polite precharge
        issue(WR, 0, 2'd2, 0, 0, 0, 0, 0, "R8 write BL8 b0");
        issue(RD, 0, 2'd0, 0, 1, 0, 1, 3, "R4 truncating read");
        issue(PR, 0, 2'd0, 0, 0, 3, 0, 0, "R6 precharge after truncation");
        idle(20);
        // R4, R5, R7: truncating precharge
        issue(WR, 1, 2'd1, 0, 0, 0, 0, 0, "R8 write BL4 b1");
        issue(PR, 1, 2'd0, 0, 1, 0, 1, 1, "R4 truncating precharge");
        issue(WR, 1, 2'd1, 0, 0, 2, 0, 0, "R7 write after trunc precharge");
        idle(20);
        // R4: last pair only, nothing discarded
        issue(WR, 2, 2'd0, 0, 0, 0, 0, 0, "R8 write BL2 b2");
        issue(RD, 2, 2'd0, 0, 1, 0, 0, 0, "R4 truncating read on last pair");
        idle(20);
        // R9: auto-precharge vs manual earliest precharge, both free at W+9
        issue(WR, 3, 2'd1, 1, 0, 0, 0, 0, "R9 auto-precharge write");
        issue(RD, 3, 2'd0, 0, 1, 8, 0, 0, "R9 read after auto-precharge");
        idle(20);
        issue(WR, 2, 2'd1, 0, 0, 0, 0, 0, "R9 manual write");
        issue(PR, 2, 2'd0, 0, 0, 5, 0, 0, "R9 manual precharge");
        issue(WR, 2, 2'd1, 0, 0, 2, 0, 0, "R9 write after manual close");
        idle(20);
        // R8: back-to-back writes restart the intervals
        issue(WR, 0, 2'd1, 0, 0, 0, 0, 0, "R8 first write");
        issue(WR, 0, 2'd1, 0, 0, 0, 0, 0, "R8 chained write");
        issue(RD, 0, 2'd0, 0, 0, 4, 0, 0, "R8 read after chained write");
        idle(20);
        chk(gq.size() == 0, "R1 grants still expected", gq.size(), 0);
        chk(mq.size() == 0, "R5 mask runs still expected", mq.size(), 0);
        finish_run();
    end

endmodule